// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Window

This block is the scheduling window of an out-of-order core. It has a fixed set of slots, and each slot holds one instruction tag. A tag carries a 16-bit sequence number, a class code, an operand-ready bit and a non-speculative marker. In every cycle the window picks the ready, released slots to issue.

Selection runs oldest-first inside each class. It respects a per-class issue width and then a shared per-cycle total, and the total is also filled oldest-first across classes. The window reports how many slots are free and raises a full flag when none are left. A squash request removes every entry younger than a given sequence number. A non-speculative entry stays parked until a commit release names its sequence number.

Each slot runs a small lifecycle machine with three states:
- **S_FREE**: the slot is empty.
- **S_HELD**: the slot holds a non-speculative entry that is waiting for release.
- **S_LIVE**: the slot holds an entry that may issue once it is ready.

The machine has these transitions:
- **S_FREE→S_HELD**: insert of a non-speculative tag.
- **S_FREE→S_LIVE**: insert of an ordinary tag.
- **S_HELD→S_LIVE**: a release whose sequence number matches the slot.
- **S_HELD→S_FREE**: squash.
- **S_LIVE→S_FREE**: issue or squash.

Top module: `iq_issue_window`

## Requirements
- R1: After reset all slots are empty: `free_cnt` equals the slot count (8), `full` is 0 and `issue_mask` is 0.
- R2: An insert is accepted when `ins_valid` is 1, `full` is 0 and `sq_valid` is 0. The entry goes to the lowest-numbered free slot, and `free_cnt` drops by one in the next cycle.
- R3: `full` is 1 exactly when `free_cnt` is 0. While `full` is 1 an insert is refused and changes nothing.
- R4: A slot issues only when its ready bit is set. The ready bit is set by `ins_ready` at insert or by a `wake` pulse on that slot's bit, and it takes effect the cycle after the pulse. A wake pulse on a free slot is ignored.
- R5: Within one class, ready entries issue in increasing sequence-number order (smaller is older).
- R6: Class codes are 0 integer, 1 floating point, 2 branch, 3 memory and 4 miscellaneous. At most 2 integer, 1 floating-point, 1 branch, 1 memory and 3 miscellaneous entries issue per cycle.
- R7: At most 3 entries issue per cycle in total. When more class-selected candidates exist, the oldest 3 win regardless of class.
- R8: An entry inserted with `ins_nonspec`=1 never issues until a `rel_valid` pulse carries its sequence number. A release carrying any other number has no effect on it.
- R9: A `sq_valid` pulse frees, by the next cycle, every occupied slot whose sequence number is greater than `sq_seq`. Slots with an equal or smaller number are kept.
- R10: Squash wins over issue: a slot being squashed in a cycle is not in that cycle's `issue_mask`, and an insert offered in a squash cycle is ignored.
- R11: A slot shown in `issue_mask` is freed at the next clock edge, so `free_cnt` rises by the issue count in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | 16 | Sequence number of the inserted entry |
| ins_cls | input | 3 | Class code of the inserted entry |
| ins_ready | input | 1 | Operands already available at insert |
| ins_nonspec | input | 1 | Entry must wait for a commit release |
| wake | input | 8 | Per-slot operand-ready pulses |
| rel_valid | input | 1 | Commit release strobe |
| rel_seq | input | 16 | Sequence number being released |
| sq_valid | input | 1 | Squash strobe |
| sq_seq | input | 16 | Entries younger than this are removed |
| issue_mask | output | 8 | Slots issuing in this cycle |
| free_cnt | output | 4 | Number of empty slots |
| full | output | 1 | No empty slot remains |

## Verification
The selector is tried with several batches of waiting entries that are woken together.

- **Mixed integer and floating-point batch.** It has more integer entries than the integer width, inserted in descending age order. This separates true oldest-first choice from slot-index order, and it also exercises the per-class cap.
- **Spread batch.** It spans branch, memory, miscellaneous and integer entries and exceeds the total width. This separates global age order from class order.
- **Held-entry pattern.** It sends a mismatched release and then a matching one, which distinguishes sequence matching from a plain release strobe.
- **Squash patterns.** One squash hits ready entries in the same cycle they would issue. A second leaves the boundary entry in place. A third empties a full window, which probes the strictly-younger comparison and squash priority.

// File: rtl/iq_pkg.sv
`timescale 1ns/1ps
package iq_pkg;
    typedef enum logic [2:0] {
        CL_INT  = 3'd0,
        CL_FP   = 3'd1,
        CL_BR   = 3'd2,
        CL_MEM  = 3'd3,
        CL_MISC = 3'd4
    } iclass_t;

    localparam int NCLASS = 5;

    typedef enum logic [1:0] {
        S_FREE = 2'd0,
        S_HELD = 2'd1,
        S_LIVE = 2'd2
    } slot_st_t;
endpackage

// File: rtl/iq_slot.sv
`timescale 1ns/1ps
module iq_slot
    import iq_pkg::*;
#(
    parameter int SEQW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [SEQW-1:0] ld_seq,
    input  iclass_t         ld_cls,
    input  logic            ld_rdy,
    input  logic            ld_ns,
    input  logic            wake,
    input  logic            rel_v,
    input  logic [SEQW-1:0] rel_seq,
    input  logic            sq_v,
    input  logic [SEQW-1:0] sq_seq,
    input  logic            issue,
    output logic            busy,
    output logic            elig,
    output logic            kill,
    output logic [SEQW-1:0] seq_o,
    output iclass_t         cls_o
);
    slot_st_t        st;
    logic            rdy;
    logic [SEQW-1:0] seq_q;
    iclass_t         cls_q;

    always_comb begin
        busy  = (st != S_FREE);
        kill  = sq_v && busy && (seq_q > sq_seq);
        elig  = (st == S_LIVE) && rdy && !kill;
        seq_o = seq_q;
        cls_o = cls_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_FREE;
            rdy   <= 1'b0;
            seq_q <= '0;
            cls_q <= CL_INT;
        end else begin
            unique case (st)
                S_FREE: begin
                    if (load) begin
                        st    <= ld_ns ? S_HELD : S_LIVE;
                        seq_q <= ld_seq;
                        cls_q <= ld_cls;
                        rdy   <= ld_rdy | wake;
                    end
                end
                S_HELD: begin
                    rdy <= rdy | wake;
                    if (kill) begin
                        st  <= S_FREE;
                        rdy <= 1'b0;
                    end else if (rel_v && rel_seq == seq_q) begin
                        st <= S_LIVE;
                    end
                end
                S_LIVE: begin
                    rdy <= rdy | wake;
                    if (kill || issue) begin
                        st  <= S_FREE;
                        rdy <= 1'b0;
                    end
                end
                default: st <= S_FREE;
            endcase
        end
    end

    a_r8_held_never_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_HELD) |-> !issue);
    a_r10_killed_not_issued: assert property (@(posedge clk) disable iff (!rst_n)
        kill |-> !issue);
    a_r9_killed_slot_frees: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> (st == S_FREE));
    a_r11_issued_slot_frees: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (st == S_FREE));
    a_r4_issue_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> rdy);
endmodule

// File: rtl/iq_select.sv
`timescale 1ns/1ps
module iq_select
    import iq_pkg::*;
#(
    parameter int N        = 8,
    parameter int SEQW     = 16,
    parameter int CAP_INT  = 2,
    parameter int CAP_FP   = 1,
    parameter int CAP_BR   = 1,
    parameter int CAP_MEM  = 1,
    parameter int CAP_MISC = 3,
    parameter int TOTAL    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    elig,
    input  logic [SEQW-1:0] seq_arr [N],
    input  iclass_t         cls_arr [N],
    output logic [N-1:0]    grant
);
    localparam int RW = $clog2(N + 1);

    function automatic int cap_of(input iclass_t c);
        case (c)
            CL_INT:  return CAP_INT;
            CL_FP:   return CAP_FP;
            CL_BR:   return CAP_BR;
            CL_MEM:  return CAP_MEM;
            CL_MISC: return CAP_MISC;
            default: return 0;
        endcase
    endfunction

    function automatic logic older(input logic [SEQW-1:0] sa, input logic [SEQW-1:0] sb,
                                   input int ia, input int ib);
        return (sa < sb) || ((sa == sb) && (ia < ib));
    endfunction

    logic [RW-1:0] crank [N];
    logic [RW-1:0] trank [N];
    logic [N-1:0]  cand;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            crank[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i && elig[j] && cls_arr[j] == cls_arr[i] &&
                    older(seq_arr[j], seq_arr[i], j, i))
                    crank[i] = crank[i] + RW'(1);
            end
            cand[i] = elig[i] && (int'(crank[i]) < cap_of(cls_arr[i]));
        end
        for (int i = 0; i < N; i++) begin
            trank[i] = '0;
            for (int j = 0; j < N; j++) begin
                if (j != i && cand[j] && older(seq_arr[j], seq_arr[i], j, i))
                    trank[i] = trank[i] + RW'(1);
            end
            grant[i] = cand[i] && (int'(trank[i]) < TOTAL);
        end
    end

    for (genvar c = 0; c < NCLASS; c++) begin : g_cls_chk
        logic [N-1:0] cls_grant;
        always_comb begin
            for (int i = 0; i < N; i++)
                cls_grant[i] = grant[i] && (cls_arr[i] == iclass_t'(c));
        end
        a_r6_class_cap: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(cls_grant) <= cap_of(iclass_t'(c)));
    end
endmodule

// File: rtl/iq_issue_window.sv
`timescale 1ns/1ps
module iq_issue_window
    import iq_pkg::*;
#(
    parameter int N        = 8,
    parameter int SEQW     = 16,
    parameter int CAP_INT  = 2,
    parameter int CAP_FP   = 1,
    parameter int CAP_BR   = 1,
    parameter int CAP_MEM  = 1,
    parameter int CAP_MISC = 3,
    parameter int TOTAL    = 3,
    localparam int CW      = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ins_valid,
    input  logic [SEQW-1:0] ins_seq,
    input  logic [2:0]      ins_cls,
    input  logic            ins_ready,
    input  logic            ins_nonspec,
    input  logic [N-1:0]    wake,
    input  logic            rel_valid,
    input  logic [SEQW-1:0] rel_seq,
    input  logic            sq_valid,
    input  logic [SEQW-1:0] sq_seq,
    output logic [N-1:0]    issue_mask,
    output logic [CW-1:0]   free_cnt,
    output logic            full
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]    busy;
    logic [N-1:0]    elig;
    logic [N-1:0]    kill;
    logic [N-1:0]    load;
    logic [SEQW-1:0] seq_arr [N];
    iclass_t         cls_arr [N];
    logic [IW-1:0]   alloc_idx;
    logic            accept;

    always_comb begin
        free_cnt  = '0;
        alloc_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                free_cnt  = free_cnt + CW'(1);
                alloc_idx = IW'(i);
            end
        end
        full   = (free_cnt == '0);
        accept = ins_valid && !full && !sq_valid;
        for (int i = 0; i < N; i++)
            load[i] = accept && (alloc_idx == IW'(i));
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        iq_slot #(.SEQW(SEQW)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load[i]),
            .ld_seq  (ins_seq),
            .ld_cls  (iclass_t'(ins_cls)),
            .ld_rdy  (ins_ready),
            .ld_ns   (ins_nonspec),
            .wake    (wake[i]),
            .rel_v   (rel_valid),
            .rel_seq (rel_seq),
            .sq_v    (sq_valid),
            .sq_seq  (sq_seq),
            .issue   (issue_mask[i]),
            .busy    (busy[i]),
            .elig    (elig[i]),
            .kill    (kill[i]),
            .seq_o   (seq_arr[i]),
            .cls_o   (cls_arr[i])
        );
    end

    iq_select #(
        .N(N), .SEQW(SEQW), .CAP_INT(CAP_INT), .CAP_FP(CAP_FP), .CAP_BR(CAP_BR),
        .CAP_MEM(CAP_MEM), .CAP_MISC(CAP_MISC), .TOTAL(TOTAL)
    ) u_select (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig),
        .seq_arr (seq_arr),
        .cls_arr (cls_arr),
        .grant   (issue_mask)
    );

    a_r7_total_cap: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(issue_mask) <= TOTAL);
    a_r3_full_refuses: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !sq_valid && issue_mask == '0) |=> full);
    a_r2_insert_takes_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !full && !sq_valid && issue_mask == '0) |=>
        (free_cnt == $past(free_cnt) - CW'(1)));
    a_r10_no_issue_of_killed: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_mask & kill) == '0);
endmodule

// File: tb/tb_iq_issue_window.sv
`timescale 1ns/1ps
module tb_iq_issue_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [15:0] ins_seq = '0;
    logic [2:0]  ins_cls = '0;
    logic        ins_ready = 1'b0;
    logic        ins_nonspec = 1'b0;
    logic [7:0]  wake = '0;
    logic        rel_valid = 1'b0;
    logic [15:0] rel_seq = '0;
    logic        sq_valid = 1'b0;
    logic [15:0] sq_seq = '0;
    logic [7:0]  issue_mask;
    logic [3:0]  free_cnt;
    logic        full;

    always #2 clk = ~clk;

    iq_issue_window dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_seq(ins_seq),
        .ins_cls(ins_cls), .ins_ready(ins_ready), .ins_nonspec(ins_nonspec),
        .wake(wake), .rel_valid(rel_valid), .rel_seq(rel_seq),
        .sq_valid(sq_valid), .sq_seq(sq_seq), .issue_mask(issue_mask),
        .free_cnt(free_cnt), .full(full)
    );

    typedef struct {
        logic [7:0] mask;
        int         fcnt;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    int total = 0;
    int bad = 0;

    // staged stimulus for the next cycle
    logic        s_iv = 1'b0;
    logic [15:0] s_is = '0;
    logic [2:0]  s_ic = '0;
    logic        s_ir = 1'b0;
    logic        s_ins = 1'b0;
    logic [7:0]  s_wk = '0;
    logic        s_rv = 1'b0;
    logic [15:0] s_rs = '0;
    logic        s_sv = 1'b0;
    logic [15:0] s_ss = '0;

    task automatic set_ins(input int seq, input int cls, input logic rdy, input logic ns);
        s_iv = 1'b1; s_is = 16'(seq); s_ic = 3'(cls); s_ir = rdy; s_ins = ns;
    endtask
    task automatic set_wake(input logic [7:0] v); s_wk = v; endtask
    task automatic set_rel(input int s); s_rv = 1'b1; s_rs = 16'(s); endtask
    task automatic set_sq(input int s); s_sv = 1'b1; s_ss = 16'(s); endtask

    task automatic step(input logic [7:0] em, input int ef, input string tag);
        exp_t e;
        @(negedge clk);
        ins_valid = s_iv; ins_seq = s_is; ins_cls = s_ic; ins_ready = s_ir;
        ins_nonspec = s_ins; wake = s_wk; rel_valid = s_rv; rel_seq = s_rs;
        sq_valid = s_sv; sq_seq = s_ss;
        e.mask = em; e.fcnt = ef; e.tag = tag;
        sb_q.push_back(e);
        s_iv = 1'b0; s_ir = 1'b0; s_ins = 1'b0; s_wk = '0; s_rv = 1'b0; s_sv = 1'b0;
    endtask

    // monitor: compare outputs of each driven cycle against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (issue_mask !== e.mask) begin
                    bad++;
                    $display("FAIL %s issue_mask act=%h exp=%h", e.tag, issue_mask, e.mask);
                end
                total++;
                if (int'(free_cnt) != e.fcnt) begin
                    bad++;
                    $display("FAIL %s free_cnt act=%0d exp=%0d", e.tag, free_cnt, e.fcnt);
                end
                total++;
                if (full !== (e.fcnt == 0)) begin
                    bad++;
                    $display("FAIL %s full act=%b exp=%b", e.tag, full, (e.fcnt == 0));
                end
            end
        end
    end

    initial begin
        #800000;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(8'h00, 8, "R1 reset");
        // R5 R6: integer and floating batch, woken together
        set_ins(30, 0, 0, 0); step(8'h00, 8, "R2 insert");
        set_ins(20, 0, 0, 0); step(8'h00, 7, "R2 insert");
        set_ins(10, 0, 0, 0); step(8'h00, 6, "R2 insert");
        set_ins(15, 1, 0, 0); step(8'h00, 5, "R2 insert");
        set_ins(12, 1, 0, 0); step(8'h00, 4, "R2 insert");
        set_wake(8'h1F);      step(8'h00, 3, "R4 wake latency");
        step(8'h16, 3, "R5 R6 oldest per class");
        step(8'h09, 6, "R11 freed after issue");
        step(8'h00, 8, "R11 freed after issue");
        // R7: spread batch over total cap
        set_ins(40, 2, 0, 0); step(8'h00, 8, "R2 insert");
        set_ins(41, 3, 0, 0); step(8'h00, 7, "R2 insert");
        set_ins(42, 4, 0, 0); step(8'h00, 6, "R2 insert");
        set_ins(43, 4, 0, 0); step(8'h00, 5, "R2 insert");
        set_ins(44, 0, 0, 0); step(8'h00, 4, "R2 insert");
        set_wake(8'h1F);      step(8'h00, 3, "R4 wake latency");
        step(8'h07, 3, "R7 oldest three overall");
        step(8'h18, 6, "R7 remainder");
        step(8'h00, 8, "R11 drained");
        // R8: non-speculative hold
        set_ins(50, 0, 1, 1); step(8'h00, 8, "R8 held insert");
        set_ins(51, 0, 1, 0); step(8'h00, 7, "R8 held not issued");
        set_rel(99);          step(8'h02, 6, "R8 only speculative issues");
        step(8'h00, 7, "R8 mismatched release ignored");
        set_rel(50);          step(8'h00, 7, "R8 release latency");
        step(8'h01, 7, "R8 released entry issues");
        step(8'h00, 8, "R11 drained");
        // R4: wake to a free slot ignored
        set_wake(8'h01);      step(8'h00, 8, "R4 wake on free slot");
        set_ins(60, 0, 0, 0); step(8'h00, 8, "R2 insert");
        step(8'h00, 7, "R4 stale wake ignored");
        set_wake(8'h01);      step(8'h00, 7, "R4 wake latency");
        step(8'h01, 7, "R4 woken entry issues");
        step(8'h00, 8, "R11 drained");
        // R9 R10: squash in issue cycle
        set_ins(70, 0, 0, 0); step(8'h00, 8, "R2 insert");
        set_ins(71, 1, 0, 0); step(8'h00, 7, "R2 insert");
        set_ins(72, 2, 0, 0); step(8'h00, 6, "R2 insert");
        set_ins(73, 3, 0, 0); step(8'h00, 5, "R2 insert");
        set_wake(8'h0F);      step(8'h00, 4, "R4 wake latency");
        set_sq(70); set_ins(80, 0, 1, 0); step(8'h01, 4, "R10 squash beats issue");
        step(8'h00, 8, "R10 insert ignored in squash");
        // R9: equal number is kept
        set_ins(90, 0, 0, 0); step(8'h00, 8, "R2 insert");
        set_ins(91, 0, 0, 0); step(8'h00, 7, "R2 insert");
        set_ins(92, 0, 0, 0); step(8'h00, 6, "R2 insert");
        set_sq(91);           step(8'h00, 5, "R9 squash cycle");
        step(8'h00, 6, "R9 younger removed");
        set_wake(8'h07);      step(8'h00, 6, "R9 wake");
        step(8'h03, 6, "R9 equal and older kept");
        step(8'h00, 8, "R11 drained");
        // R3: fill the window
        for (int k = 0; k < 8; k++) begin
            set_ins(100 + k, 0, 0, 0); step(8'h00, 8 - k, "R3 filling");
        end
        set_ins(200, 0, 1, 0); step(8'h00, 0, "R3 full refuses insert");
        set_wake(8'h01);       step(8'h00, 0, "R3 still full");
        step(8'h01, 0, "R3 slot0 issues");
        set_sq(0);             step(8'h00, 1, "R9 squash all younger");
        step(8'h00, 8, "R9 window emptied");
        step(8'h00, 8, "R1 idle");
        @(negedge clk); #2;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule